// File: doc/BRIEF.md
# Data Integrity Tuple Generator

This block sits in a storage write path and builds an 8-byte protection tuple for every logical block that streams through it one byte per clock. A command begins with a single-cycle start pulse. The pulse captures four settings: the first reference tag, the application tag, the protection type and whether the tuple sits at the head or at the tail of the per-block metadata area.

After the pulse the block accepts the data bytes of each logical block over a valid/ready byte interface. With tail placement, the metadata bytes that come ahead of the tuple follow the data bytes. A 16-bit guard CRC runs over every byte the block accepts. After the last byte of a block, the block presents the finished tuple on a 64-bit output with a valid/ready handshake. The guard, the command's application tag and the current reference tag make up the tuple. The reference tag then moves on to the next block's value.

While a tuple waits on the output, the input stops accepting bytes, so no byte and no tuple is ever dropped. A new start pulse abandons any partly received block and begins a fresh command.

Top module: `dtg_tuple_gen`

## Requirements
- R1: After reset, and until the first start pulse, in_ready_o and tup_valid_o are both 0, whatever in_valid_i does.
- R2: The reference tag, application tag, protection type and placement are captured only on the cycle start_i is 1. Later changes on those configuration inputs have no effect on the command in progress.
- R3: The guard is a CRC16 with polynomial 0x8BB7, initial value 0, most significant bit first, no reflection and no final XOR. It covers every byte accepted for the block, starting with the BLK_BYTES data bytes.
- R4: With cfg_head_i = 0 (tuple at the tail), each block is BLK_BYTES data bytes followed by META_BYTES-8 metadata bytes. All of them enter the guard, and the tuple follows the last of them.
- R5: With cfg_head_i = 1 (tuple at the head), each block is exactly BLK_BYTES data bytes, and no metadata byte enters the guard.
- R6: tup_data_o carries the guard in bits [63:48], the application tag in [47:32] and the reference tag in [31:0], so byte 0 of the tuple is bits [63:56] (big-endian).
- R7: Every tuple of one command carries the application tag captured at start.
- R8: The first tuple carries the captured reference tag. With protection type code 3 every later tuple carries the same value. With any other code each block's tag is the previous one plus 1, modulo 2^32.
- R9: While tup_valid_o is 1 and tup_ready_i is 0, in_ready_o is 0 and tup_valid_o and tup_data_o hold. Every block yields exactly one tuple.
- R10: A start pulse in the middle of a block discards the partial block. No tuple is made for it, and the byte count and guard restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Command start pulse, captures the configuration |
| cfg_reftag_i | input | 32 | First reference tag of the command |
| cfg_apptag_i | input | 16 | Application tag for every block |
| cfg_ptype_i | input | 2 | Protection type code (3 keeps the reference tag fixed) |
| cfg_head_i | input | 1 | 1: tuple at head of metadata, 0: tuple at tail |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Input byte accepted when high with in_valid_i |
| tup_valid_o | output | 1 | Tuple valid |
| tup_data_o | output | 64 | Tuple: guard, application tag, reference tag |
| tup_ready_i | input | 1 | Tuple consumer ready |

## Verification
The bound checker watches the handshake and tag bookkeeping on every cycle. It checks that a stalled tuple holds and that each finished block produces a tuple. It checks that the tuple fields match the application and reference tags held at that moment, that the reference tag steps or stays put according to the protection type, and that a start pulse clears the byte position. The guard value is only shown by the bench scenarios. They compare it against a bit-serial CRC model over random data in both placements and over an all-zero block, and they also cover reference tag wrap, configuration changes during a command, a start pulse inside a block and random output backpressure.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  localparam int TUPLE_BYTES = 8;
  localparam logic [1:0] PTYPE_FIXED_REF = 2'd3;

  typedef struct packed {
    logic [15:0] guard;
    logic [15:0] app_tag;
    logic [31:0] ref_tag;
  } tuple_t;

  // One byte step of a non-reflected CRC16, MSB first.
  function automatic logic [15:0] crc16_byte(input logic [15:0] crc,
                                             input logic [7:0]  data,
                                             input logic [15:0] poly);
    logic [15:0] c;
    c = crc ^ {data, 8'h00};
    for (int i = 0; i < 8; i++) begin
      if (c[15]) c = (c << 1) ^ poly;
      else       c = c << 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/dtg_crc_unit.sv
module dtg_crc_unit #(
  parameter logic [15:0] CRC_POLY = 16'h8BB7
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clear_i,
  input  logic        step_i,
  input  logic        close_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_next_o
);
  import dtg_pkg::*;

  logic [15:0] crc_q;

  assign crc_next_o = crc16_byte(crc_q, data_i, CRC_POLY);

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= '0;
    end else if (clear_i || (step_i && close_i)) begin
      crc_q <= '0;
    end else if (step_i) begin
      crc_q <= crc_next_o;
    end
  end

endmodule

// File: rtl/dtg_block_seq.sv
module dtg_block_seq #(
  parameter int BLK_BYTES  = 512,
  parameter int META_BYTES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic head_i,
  input  logic step_i,
  output logic last_o,
  output logic cnt_zero_o
);
  import dtg_pkg::*;

  localparam int PREFIX_TAIL = META_BYTES - TUPLE_BYTES;
  localparam int SPAN_MAX    = BLK_BYTES + PREFIX_TAIL;
  localparam int CW          = $clog2(SPAN_MAX + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_idx;
  logic          head_q;

  always_ff @(posedge clk) begin
    if (rst)          head_q <= 1'b1;
    else if (start_i) head_q <= head_i;
  end

  generate
    if (PREFIX_TAIL == 0) begin : g_no_prefix
      assign last_idx = CW'(BLK_BYTES - 1);
    end else begin : g_prefix
      assign last_idx = head_q ? CW'(BLK_BYTES - 1) : CW'(SPAN_MAX - 1);
    end
  endgenerate

  assign last_o     = (cnt_q == last_idx);
  assign cnt_zero_o = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/dtg_tag_unit.sv
module dtg_tag_unit (
  input  logic        clk,
  input  logic        rst,
  input  logic        load_i,
  input  logic [31:0] ref_i,
  input  logic [15:0] app_i,
  input  logic [1:0]  ptype_i,
  input  logic        advance_i,
  output logic [31:0] ref_o,
  output logic [15:0] app_o,
  output logic        fixed_o
);
  import dtg_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_o   <= '0;
      app_o   <= '0;
      fixed_o <= 1'b0;
    end else if (load_i) begin
      ref_o   <= ref_i;
      app_o   <= app_i;
      fixed_o <= (ptype_i == PTYPE_FIXED_REF);
    end else if (advance_i && !fixed_o) begin
      ref_o   <= ref_o + 32'd1;
    end
  end

endmodule

// File: rtl/dtg_tuple_gen.sv
module dtg_tuple_gen #(
  parameter int          BLK_BYTES  = 512,
  parameter int          META_BYTES = 16,
  parameter logic [15:0] CRC_POLY   = 16'h8BB7
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic [31:0] cfg_reftag_i,
  input  logic [15:0] cfg_apptag_i,
  input  logic [1:0]  cfg_ptype_i,
  input  logic        cfg_head_i,
  input  logic        in_valid_i,
  input  logic [7:0]  in_data_i,
  output logic        in_ready_o,
  output logic        tup_valid_o,
  output logic [63:0] tup_data_o,
  input  logic        tup_ready_i
);
  import dtg_pkg::*;

  logic        armed_q;
  logic        stall;
  logic        accept;
  logic        last_byte;
  logic        blk_done;
  logic        cnt_zero;
  logic [15:0] crc_next;
  logic [31:0] ref_q;
  logic [15:0] app_q;
  logic        fixed_ref;
  tuple_t      tup_q;

  always_ff @(posedge clk) begin
    if (rst)          armed_q <= 1'b0;
    else if (start_i) armed_q <= 1'b1;
  end

  assign stall      = tup_valid_o && !tup_ready_i;
  assign in_ready_o = armed_q && !stall && !start_i;
  assign accept     = in_valid_i && in_ready_o;
  assign blk_done   = accept && last_byte;

  dtg_block_seq #(.BLK_BYTES(BLK_BYTES), .META_BYTES(META_BYTES)) seq_i (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .head_i     (cfg_head_i),
    .step_i     (accept),
    .last_o     (last_byte),
    .cnt_zero_o (cnt_zero)
  );

  dtg_crc_unit #(.CRC_POLY(CRC_POLY)) crc_i (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (start_i),
    .step_i     (accept),
    .close_i    (last_byte),
    .data_i     (in_data_i),
    .crc_next_o (crc_next)
  );

  dtg_tag_unit tag_i (
    .clk       (clk),
    .rst       (rst),
    .load_i    (start_i),
    .ref_i     (cfg_reftag_i),
    .app_i     (cfg_apptag_i),
    .ptype_i   (cfg_ptype_i),
    .advance_i (blk_done),
    .ref_o     (ref_q),
    .app_o     (app_q),
    .fixed_o   (fixed_ref)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tup_valid_o <= 1'b0;
      tup_q       <= '0;
    end else if (blk_done) begin
      tup_valid_o   <= 1'b1;
      tup_q.guard   <= crc_next;
      tup_q.app_tag <= app_q;
      tup_q.ref_tag <= ref_q;
    end else if (tup_ready_i) begin
      tup_valid_o <= 1'b0;
    end
  end

  assign tup_data_o = tup_q;

endmodule

// File: rtl/dtg_tuple_gen_chk.sv
module dtg_tuple_gen_chk (
  input logic        clk,
  input logic        rst,
  input logic        start_i,
  input logic        tup_valid_o,
  input logic        tup_ready_i,
  input logic [63:0] tup_data_o,
  input logic        blk_done,
  input logic        fixed_ref,
  input logic [31:0] ref_q,
  input logic [15:0] app_q,
  input logic        cnt_zero
);

  // R9
  tuple_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tup_valid_o && !tup_ready_i) |=> (tup_valid_o && $stable(tup_data_o)));

  // R9
  block_emits_chk: assert property (@(posedge clk) disable iff (rst)
    blk_done |=> tup_valid_o);

  // R6
  ref_field_chk: assert property (@(posedge clk) disable iff (rst)
    blk_done |=> (tup_data_o[31:0] == $past(ref_q)));

  // R7
  app_field_chk: assert property (@(posedge clk) disable iff (rst)
    blk_done |=> (tup_data_o[47:32] == $past(app_q)));

  // R8
  ref_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (blk_done && fixed_ref && !start_i) |=> $stable(ref_q));

  // R8
  ref_step_chk: assert property (@(posedge clk) disable iff (rst)
    (blk_done && !fixed_ref && !start_i) |=> (ref_q == $past(ref_q) + 32'd1));

  // R10
  restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> cnt_zero);

endmodule

bind dtg_tuple_gen dtg_tuple_gen_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .tup_valid_o (tup_valid_o),
  .tup_ready_i (tup_ready_i),
  .tup_data_o  (tup_data_o),
  .blk_done    (blk_done),
  .fixed_ref   (fixed_ref),
  .ref_q       (ref_q),
  .app_q       (app_q),
  .cnt_zero    (cnt_zero)
);

// File: tb/dtg_tuple_gen_tb_top.sv
module dtg_tuple_gen_tb_top;

  localparam int BLK  = 32;
  localparam int META = 16;
  localparam int PFX  = META - 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] cfg_reftag_i = '0;
  logic [15:0] cfg_apptag_i = '0;
  logic [1:0]  cfg_ptype_i = '0;
  logic        cfg_head_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [7:0]  in_data_i = '0;
  logic        in_ready_o;
  logic        tup_valid_o;
  logic [63:0] tup_data_o;
  logic        tup_ready_i = 1'b0;

  int total = 0;
  int bad = 0;
  int pushed = 0;
  int seen = 0;
  bit done = 1'b0;
  bit bp_on = 1'b0;

  logic [63:0] exp_q[$];
  bit          head_q[$];

  always #2 clk = ~clk;

  dtg_tuple_gen #(.BLK_BYTES(BLK), .META_BYTES(META)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .cfg_reftag_i (cfg_reftag_i),
    .cfg_apptag_i (cfg_apptag_i),
    .cfg_ptype_i  (cfg_ptype_i),
    .cfg_head_i   (cfg_head_i),
    .in_valid_i   (in_valid_i),
    .in_data_i    (in_data_i),
    .in_ready_o   (in_ready_o),
    .tup_valid_o  (tup_valid_o),
    .tup_data_o   (tup_data_o),
    .tup_ready_i  (tup_ready_i)
  );

  // Bit-serial reference model of the guard.
  function automatic logic [15:0] model_crc(input logic [15:0] crc, input logic [7:0] b);
    logic [15:0] c;
    logic        fb;
    c = crc;
    for (int k = 7; k >= 0; k--) begin
      fb = c[15] ^ b[k];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h8BB7;
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid_i = 1'b1;
    in_data_i  = b;
    #1;
    while (!in_ready_o) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  task automatic start_cmd(input logic [31:0] rt, input logic [15:0] at,
                           input logic [1:0] pt, input bit head);
    @(negedge clk);
    start_i      = 1'b1;
    cfg_reftag_i = rt;
    cfg_apptag_i = at;
    cfg_ptype_i  = pt;
    cfg_head_i   = head;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_cmd(input logic [31:0] rt, input logic [15:0] at,
                         input logic [1:0] pt, input bit head,
                         input int nblk, input bit zero, input bit scramble_cfg);
    logic [31:0] r;
    logic [15:0] crc;
    logic [7:0]  b;
    int          span;
    start_cmd(rt, at, pt, head);
    if (scramble_cfg) begin
      cfg_reftag_i = ~rt;
      cfg_apptag_i = ~at;
      cfg_ptype_i  = pt ^ 2'd2;
      cfg_head_i   = ~head;
    end
    r    = rt;
    span = head ? BLK : BLK + PFX;
    for (int n = 0; n < nblk; n++) begin
      crc = 16'h0000;
      for (int i = 0; i < span; i++) begin
        b   = zero ? 8'h00 : 8'($urandom);
        crc = model_crc(crc, b);
        if (i == span - 1) begin
          exp_q.push_back({crc, at, r});
          head_q.push_back(head);
          pushed++;
        end
        send_byte(b);
      end
      if (pt != 2'd3) r = r + 32'd1;
    end
  endtask

  // Monitor / scoreboard
  initial begin
    logic [63:0] e;
    bit          h;
    forever begin
      @(negedge clk);
      tup_ready_i = bp_on ? ($urandom_range(0, 3) != 0) : 1'b1;
      #1;
      if (done) break;
      if (tup_valid_o && tup_ready_i && !rst) begin
        seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected tuple", tup_data_o, 64'h0);
        end else begin
          e = exp_q.pop_front();
          h = head_q.pop_front();
          if (h) check(tup_data_o[63:48] == e[63:48], "R3/R5 guard (head)", tup_data_o, e);
          else   check(tup_data_o[63:48] == e[63:48], "R3/R4 guard (tail)", tup_data_o, e);
          check(tup_data_o[47:32] == e[47:32], "R6/R7/R2 application tag", tup_data_o, e);
          check(tup_data_o[31:0]  == e[31:0],  "R6/R8/R2 reference tag", tup_data_o, e);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog expired, pending=%0d expected=0", exp_q.size());
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: idle before first start even with input offered
    in_valid_i = 1'b1;
    in_data_i  = 8'h5A;
    repeat (3) begin
      @(negedge clk);
      #1;
      check(in_ready_o == 1'b0, "R1 in_ready idle", 64'(in_ready_o), 64'd0);
      check(tup_valid_o == 1'b0, "R1 tup_valid idle", 64'(tup_valid_o), 64'd0);
    end
    in_valid_i = 1'b0;

    // R4, R8 wrap, R2 config scramble, no backpressure
    run_cmd(32'hFFFF_FFFE, 16'h1234, 2'd1, 1'b0, 4, 1'b0, 1'b1);
    bp_on = 1'b1;
    // R5, R8 type 3 fixed, R9 with backpressure
    run_cmd(32'hABCD_0001, 16'hBEEF, 2'd3, 1'b1, 4, 1'b0, 1'b0);
    // R3/R5: all-zero block gives a zero guard in head placement
    run_cmd(32'h0000_0010, 16'h0F0F, 2'd2, 1'b1, 2, 1'b1, 1'b0);
    // R4 with type 2 under backpressure
    run_cmd(32'h0000_0100, 16'h7777, 2'd2, 1'b0, 3, 1'b0, 1'b0);

    // R10: partial block followed by a new start
    start_cmd(32'h5555_0000, 16'hDEAD, 2'd1, 1'b0);
    for (int i = 0; i < 10; i++) send_byte(8'($urandom));
    run_cmd(32'h0000_0042, 16'hC0DE, 2'd1, 1'b0, 3, 1'b0, 1'b0);

    // drain
    for (int w = 0; w < 2000 && exp_q.size() != 0; w++) @(negedge clk);
    repeat (4) @(negedge clk);
    // R9/R10: every block made exactly one tuple, partial block none
    check(exp_q.size() == 0, "R9 pending tuples", 64'(exp_q.size()), 64'd0);
    check(seen == pushed, "R10 tuple count", 64'(seen), 64'(pushed));
    #1;
    check(tup_valid_o == 1'b0, "R9 output idle after drain", 64'(tup_valid_o), 64'd0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule